// File: doc/BRIEF.md
# Programmable Weighted-Sum Pixel Filter

This block performs correlated double sampling in the digital domain for one video channel. Every clock cycle it may accept one 14-bit ADC sample. It multiplies the sample by a signed weight read from a local coefficient table and adds the product into a wide accumulator. The weight is chosen by the sample's position inside the current pixel window. When the last sample of the window has been taken, the accumulated sum is presented for one cycle to the downstream transmitter. Because the weights are arbitrary, any filter shape can be loaded, including dual-slope or clamp-and-sample integration and any other weighting. Reloading the table and the window length before a readout trades noise against speed.

Timing control comes from the broadcast lines that also drive the waveform slaves:

- A clock enable qualifies every cycle.
- A start strobe marks the beginning of the next waveform.
- A type code names that waveform.

The channel responds only to starts whose type matches its configured pixel type. Windows of any other type produce no data.

Top module: `cds_weigher`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. No result appears until a matching window completes.
- R2: Each result equals the sum over the window of `adc_data[k]` × `coef[k]`, where k is the sample's position in the window (0 for the first sample). `adc_data` is 14-bit two's complement, `coef` is 16-bit two's complement, and the sum is sign-extended to 44 bits.
- R3: A window begins on a cycle with `bc_en`=1, `bc_start`=1 and `bc_type`=`chan_type`. The sample of that cycle takes index 0, and the index advances by one on each following cycle with `bc_en`=1.
- R4: On a cycle with `bc_en`=0, the sample is ignored, the index does not advance, and a `bc_start` is ignored.
- R5: `out_valid` is 1 for exactly the cycle that follows the clock edge taking the window's last sample. `out_data` holds its value until the next result.
- R6: `win_len` is captured at the window start and gives the number of samples in the window. The value 0 acts as 1, and values above 256 act as 256.
- R7: A start whose `bc_type` differs from `chan_type` produces no output and discards any window in progress.
- R8: A matching start that arrives inside an unfinished window discards the partial sum and restarts at index 0.
- R9: A window may start on the cycle directly after the previous window's last sample, with no gap cycle. Single-sample windows started on consecutive cycles produce a result on every cycle.
- R10: With `coef_we`=1, `coef_wdata` is written to entry `coef_addr`. Samples taken from the next cycle onward use the new weight.
- R11: Full-scale operands over a 256-sample window produce the exact sum without overflow, for example 256 × (−8192) × (−32768) = 2^36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_type | input | 8 | Waveform type this channel treats as the pixel |
| coef_we | input | 1 | Coefficient table write strobe |
| coef_addr | input | 8 | Coefficient table write index |
| coef_wdata | input | 16 | Signed coefficient to write |
| win_len | input | 9 | Samples per window, captured at start |
| bc_en | input | 1 | Broadcast clock enable |
| bc_start | input | 1 | Broadcast start of next waveform |
| bc_type | input | 8 | Broadcast type of next waveform |
| adc_data | input | 14 | Signed ADC sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 44 | Signed accumulated pixel value |

## Verification
A result is due one cycle after the edge that takes the window's last sample, so `out_valid` and `out_data` are checked at the falling edge that directly follows that edge. `out_valid` is checked again one cycle later to confirm it has dropped. A coefficient write lands on the same edge as the sample driven with it, so it takes effect on the sample driven one cycle later. The bench drives all inputs on falling edges and samples outputs on the next falling edge, which counts each of these single-cycle delays exactly. Aborted or foreign windows are checked by observing `out_valid` stay low and `out_data` stay unchanged over every cycle in which the window could have ended.

// File: rtl/cds_weigher.sv
module cds_weigher #(
  parameter int SAMP_W = 14,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 44,
  parameter int DEPTH  = 256,
  parameter int TYPE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TYPE_W-1:0]       chan_type,
  input  logic                    coef_we,
  input  logic [$clog2(DEPTH)-1:0] coef_addr,
  input  logic [COEF_W-1:0]       coef_wdata,
  input  logic [$clog2(DEPTH):0]  win_len,
  input  logic                    bc_en,
  input  logic                    bc_start,
  input  logic [TYPE_W-1:0]       bc_type,
  input  logic [SAMP_W-1:0]       adc_data,
  output logic                    out_valid,
  output logic [ACC_W-1:0]        out_data
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LEN_W  = IDX_W + 1;
  localparam int PROD_W = SAMP_W + COEF_W;

  logic [COEF_W-1:0] coef_mem [DEPTH];
  logic              active;
  logic [IDX_W-1:0]  idx, last_idx, start_last, cur_idx;
  logic [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x, sum_nxt;
  logic strobe, type_hit, take, is_last;

  always_ff @(posedge clk)
    if (coef_we) coef_mem[coef_addr] <= coef_wdata;

  always_comb begin
    if (win_len == '0)                   start_last = '0;
    else if (win_len > LEN_W'(DEPTH))    start_last = IDX_W'(DEPTH - 1);
    else                                 start_last = IDX_W'(win_len - 1'b1);
  end

  assign strobe   = bc_en & bc_start;
  assign type_hit = (bc_type == chan_type);
  assign take     = bc_en & (bc_start ? type_hit : active);
  assign cur_idx  = bc_start ? '0 : idx;
  assign is_last  = bc_start ? (start_last == '0) : (idx == last_idx);
  assign prod     = $signed(adc_data) * $signed(coef_mem[cur_idx]);
  assign prod_x   = ACC_W'(prod);
  assign sum_nxt  = (strobe ? '0 : $signed(acc)) + prod_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      last_idx  <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take & is_last;
      if (strobe) begin
        active   <= type_hit & (start_last != '0);
        idx      <= IDX_W'(1);
        last_idx <= start_last;
      end else if (take) begin
        idx <= idx + 1'b1;
        if (is_last) active <= 1'b0;
      end
      if (take) acc <= sum_nxt;
      if (take & is_last) out_data <= sum_nxt;
    end
  end

  a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_en |=> ($stable(acc) && !out_valid));

  a_r3_index_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx != '0 && idx <= last_idx));

  a_r7_foreign_type: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && bc_type != chan_type) |=> (!active && !out_valid));

  a_r5_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bc_en));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/cds_weigher_test.sv
module cds_weigher_test;
  localparam int DEPTH = 256;
  localparam logic [7:0] MY = 8'h5A;
  localparam int VEC [6][3] = '{'{8,1,0}, '{16,2,1}, '{1,3,0}, '{100,4,0}, '{256,5,0}, '{33,6,1}};

  logic clk = 0, rst_n = 0;
  logic [7:0] chan_type = MY, bc_type = MY;
  logic coef_we = 0, bc_en = 0, bc_start = 0;
  logic [7:0] coef_addr = 0;
  logic [15:0] coef_wdata = 0;
  logic [8:0] win_len = 0;
  logic [13:0] adc_data = 0;
  logic out_valid;
  logic [43:0] out_data;

  int checks = 0, errors = 0;
  int shadow [DEPTH];

  cds_weigher uut (.clk(clk), .rst_n(rst_n), .chan_type(chan_type), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .win_len(win_len), .bc_en(bc_en),
    .bc_start(bc_start), .bc_type(bc_type), .adc_data(adc_data),
    .out_valid(out_valid), .out_data(out_data));

  always #2 clk = ~clk;

  function automatic int samp_f(int seed, int k);
    return ((seed * 37 + k * 1013) % 16384) - 8192;
  endfunction
  function automatic int coef_f(int seed, int k);
    return ((seed * 91 + k * 7919) % 65536) - 32768;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, bit v, longint exp);
    chk(out_valid == v, {tag, " valid"}, longint'(out_valid), longint'(v));
    if (v) chk(out_data == exp[43:0], {tag, " data"}, longint'($signed(out_data)), exp);
  endtask

  task automatic wr_coef(int a, int v);
    coef_we = 1; coef_addr = 8'(a); coef_wdata = 16'(v); shadow[a] = v;
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic drive(bit en, bit st, int len, int s);
    bc_en = en; bc_start = st; win_len = 9'(len); adc_data = 14'(s);
    @(negedge clk);
  endtask

  task automatic run_window(int len, int seed, int gaps, int usefix, int fixv, string tag);
    int eff;
    longint exp;
    eff = (len == 0) ? 1 : (len > DEPTH ? DEPTH : len);
    exp = 0;
    for (int k = 0; k < eff; k++) begin
      int s;
      if (gaps != 0 && k > 0) drive(0, 1, 3, 5000 - k);
      s = (usefix != 0) ? fixv : samp_f(seed, k);
      exp += longint'(s) * longint'(shadow[k]);
      drive(1, k == 0, len, s);
    end
    chk_out(tag, 1, exp);
    bc_en = 0; bc_start = 0;
    @(negedge clk);
    chk_out({tag, " pulse"}, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint e, prev;
    repeat (3) @(negedge clk);
    chk_out("R1 reset", 0, 0);
    chk(out_data == 0, "R1 reset data", longint'(out_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk_out("R1 idle", 0, 0);

    for (int v = 0; v < 6; v++) begin
      for (int a = 0; a < DEPTH; a++) wr_coef(a, coef_f(VEC[v][1], a));
      run_window(VEC[v][0], VEC[v][1], VEC[v][2], 0, 0,
                 VEC[v][2] != 0 ? "R4 gaps" : "R2 vector");
    end

    run_window(0, 9, 0, 0, 0, "R6 zero len");
    run_window(300, 10, 0, 0, 0, "R6 over len");
    run_window(7, 11, 1, 0, 0, "R3 R4 enable gaps");

    e = 0;
    drive(1, 1, 4, 100); drive(1, 0, 4, 200);
    e = longint'(-300) * shadow[0] + longint'(400) * shadow[1] + longint'(-500) * shadow[2];
    drive(1, 1, 3, -300);
    chk_out("R8 restart no early", 0, 0);
    drive(1, 0, 3, 400); drive(1, 0, 3, -500);
    chk_out("R8 restart", 1, e);
    bc_en = 0; @(negedge clk);

    prev = longint'($signed(out_data));
    drive(1, 1, 4, 11); drive(1, 0, 4, 22);
    bc_type = 8'h11;
    drive(1, 1, 4, 33);
    bc_type = MY;
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 4, 44);
      chk_out("R7 foreign abort", 0, 0);
    end
    chk(out_data == prev[43:0], "R7 data kept", longint'($signed(out_data)), prev);
    bc_type = 8'h22;
    drive(1, 1, 1, 55);
    bc_type = MY;
    chk_out("R7 foreign single", 0, 0);

    drive(1, 1, 3, 1); drive(1, 0, 3, 2); drive(1, 0, 3, 3);
    chk_out("R9 first", 1, shadow[0] + 2 * longint'(shadow[1]) + 3 * longint'(shadow[2]));
    drive(1, 1, 2, -7); drive(1, 0, 2, 9);
    chk_out("R9 back to back", 1, -7 * longint'(shadow[0]) + 9 * longint'(shadow[1]));
    for (int k = 1; k <= 3; k++) begin
      drive(1, 1, 1, k * 1000);
      chk_out("R9 single each cycle", 1, longint'(k * 1000) * shadow[0]);
    end
    bc_en = 0; bc_start = 0; @(negedge clk);

    coef_we = 1; coef_addr = 1; coef_wdata = 16'(-1234); shadow[1] = -1234;
    bc_en = 1; bc_start = 1; win_len = 2; adc_data = 14'(321);
    @(negedge clk);
    coef_we = 0;
    drive(1, 0, 2, -45);
    chk_out("R10 coef write", 1, 321 * longint'(shadow[0]) + (-45) * longint'(-1234));
    bc_en = 0; @(negedge clk);

    for (int a = 0; a < DEPTH; a++) wr_coef(a, -32768);
    run_window(256, 0, 0, 1, -8192, "R11 full scale neg");
    for (int a = 0; a < DEPTH; a++) wr_coef(a, 32767);
    run_window(256, 0, 0, 1, 8191, "R11 full scale pos");
    run_window(256, 0, 0, 1, -8192, "R11 full scale mixed");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule